// File: doc/BRIEF.md
# Oscillator Race Response Evaluator

This block turns a pair of free-running oscillator signals into a single response bit. Each oscillator clocks a counter of its own. After a start request from the system side, both counters are cleared and begin counting; the first to reach its all-ones value wins the race. The winner is carried into the system clock domain, where it sets the response bit and raises a done flag. The two oscillators are expected to be placed next to each other so that temperature and supply drift affect both alike, and only small manufacturing differences in their periods decide the bit.

Every signal that crosses between domains goes through a flop chain of configurable length. The start request travels into each oscillator domain as a toggle, and a halt level freezes both counters once a result is known. The terminal-count flags come back as registered levels. A new start clears the previous outcome and runs a fresh race. The evaluator waits until both returned flags read low before it will accept a winner, so a result from an earlier race is never reused.

Top module: `ro_race_eval`

## Requirements
- R1: After reset, `resp` and `done` are 0. No race runs and `done` stays 0 until the first `start` pulse.
- R2: Each oscillator clocks a counter of `CNT_W` bits (default 13) that starts from zero after each start. No result can appear before the faster oscillator has made 2^CNT_W − 1 cycles, which is at least 1550 system cycles for a 4.0 ns oscillator and a 20 ns system clock.
- R3: When only the terminal flag of oscillator A is seen first in the system domain, `resp` is 1. When only that of oscillator B is seen first, `resp` is 0.
- R4: When both synchronized terminal flags first appear in the same system cycle, `resp` takes the tie value `TIE_RESULT` (default 0).
- R5: `done` rises one system cycle after the first synchronized terminal flag is seen, and it stays high until the next `start`.
- R6: While `done` is high, `resp` holds the latched winner and both counters are frozen. Later changes in either oscillator have no effect on `resp`.
- R7: A one-cycle `start` pulse drives `done` low on the next system cycle and begins a new race, even when a race is already in progress.
- R8: Each terminal-count flag is registered in its oscillator domain and crosses into the system domain through a chain of `SYNC_STAGES` flops (at least 2). The clear and halt controls cross the other way through chains of the same length.
- R9: After a start, terminal flags left over from the previous race are ignored. A winner is accepted only after both synchronized flags have read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| osc_a | input | 1 | Oscillator A, clocks counter A |
| osc_b | input | 1 | Oscillator B, clocks counter B |
| start | input | 1 | One-cycle pulse in the system domain that clears the counters and starts a race |
| resp | output | 1 | Response bit: 1 when A finished first, 0 when B did, tie value when both finished together |
| done | output | 1 | High from one cycle after the race is decided until the next start |

## Verification
The assertions assume that `start` is a single-cycle pulse in the system domain. They also assume that both oscillators keep toggling while a race is armed, so that the clear and halt controls reach the counters. Under those assumptions, a rising `done` always traces back to a synchronized flag two samples earlier, and the latched bit then stays put. The bench drives the oscillators as free-running clocks with fixed periods and changes a period only between races or after `done`. For the tie case it feeds the same waveform to both inputs, so the flags arrive in the same cycle.

// File: rtl/ro_race_pkg.sv
package ro_race_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARM  = 2'd1,
      ST_RUN  = 2'd2,
      ST_DONE = 2'd3
   } race_state_t;

   localparam int unsigned NUM_OSC = 2;

   // Winner encoding: 1 when only A arrived, 0 when only B arrived.
   function automatic logic pick_winner(input logic a_seen, input logic b_seen,
                                        input logic tie_val);
      if (a_seen && b_seen) return tie_val;
      return a_seen;
   endfunction

endpackage

// File: rtl/ro_race_sync.sv
module ro_race_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ro_race_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/ro_race_counter.sv
module ro_race_counter #(
   parameter int unsigned CNT_W       = 13,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic osc_clk,
   input  logic rst_n,
   input  logic clr_tgl,
   input  logic halt,
   output logic tc
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             clr_s;
   logic             halt_s;
   logic             clr_prev;
   logic             clr_pulse;
   logic [CNT_W-1:0] cnt;
   logic             tc_q;

   ro_race_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_clr_sync (
      .clk(osc_clk), .rst_n(rst_n), .d(clr_tgl), .q(clr_s)
   );

   ro_race_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_halt_sync (
      .clk(osc_clk), .rst_n(rst_n), .d(halt), .q(halt_s)
   );

   assign clr_pulse = clr_s ^ clr_prev;

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_prev <= 1'b0;
         cnt      <= '0;
         tc_q     <= 1'b0;
      end else begin
         clr_prev <= clr_s;
         if (clr_pulse) begin
            cnt  <= '0;
            tc_q <= 1'b0;
         end else begin
            if (!halt_s && (cnt != CNT_MAX)) cnt <= cnt + 1'b1;
            tc_q <= (cnt == CNT_MAX);
         end
      end
   end

   assign tc = tc_q;

endmodule

// File: rtl/ro_race_arbiter.sv
module ro_race_arbiter
   import ro_race_pkg::*;
#(
   parameter logic TIE_RESULT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tc_a_s,
   input  logic tc_b_s,
   output logic halt,
   output logic clr_tgl,
   output logic resp,
   output logic done
);

   race_state_t state;
   logic        win_q;
   logic        pend_q;
   logic        halt_q;
   logic        tgl_q;
   logic        resp_q;
   logic        done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         win_q  <= 1'b0;
         pend_q <= 1'b0;
         halt_q <= 1'b1;
         tgl_q  <= 1'b0;
         resp_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         pend_q <= 1'b0;
         if (start) begin
            tgl_q  <= ~tgl_q;
            halt_q <= 1'b0;
            done_q <= 1'b0;
            resp_q <= 1'b0;
            state  <= ST_ARM;
         end else begin
            case (state)
               ST_ARM: begin
                  if (!tc_a_s && !tc_b_s) state <= ST_RUN;
               end
               ST_RUN: begin
                  if (tc_a_s || tc_b_s) begin
                     win_q  <= pick_winner(tc_a_s, tc_b_s, TIE_RESULT);
                     pend_q <= 1'b1;
                     halt_q <= 1'b1;
                     state  <= ST_DONE;
                  end
               end
               ST_DONE: begin
                  if (pend_q) begin
                     resp_q <= win_q;
                     done_q <= 1'b1;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign halt    = halt_q;
   assign clr_tgl = tgl_q;
   assign resp    = resp_q;
   assign done    = done_q;

endmodule

// File: rtl/ro_race_eval.sv
module ro_race_eval
   import ro_race_pkg::*;
#(
   parameter int unsigned CNT_W       = 13,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic        TIE_RESULT  = 1'b0
) (
   input  logic clk_sys,
   input  logic rst_n,
   input  logic osc_a,
   input  logic osc_b,
   input  logic start,
   output logic resp,
   output logic done
);

   logic [NUM_OSC-1:0] osc_v;
   logic [NUM_OSC-1:0] tc_osc;
   logic [NUM_OSC-1:0] tc_sys;
   logic               halt;
   logic               clr_tgl;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("ro_race_eval: CNT_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ro_race_eval: SYNC_STAGES must be at least 2");
      end
   endgenerate

   assign osc_v = {osc_b, osc_a};

   generate
      for (genvar g = 0; g < NUM_OSC; g++) begin : g_chan
         ro_race_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_cnt (
            .osc_clk(osc_v[g]),
            .rst_n  (rst_n),
            .clr_tgl(clr_tgl),
            .halt   (halt),
            .tc     (tc_osc[g])
         );
         ro_race_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_tc_sync (
            .clk(clk_sys), .rst_n(rst_n), .d(tc_osc[g]), .q(tc_sys[g])
         );
      end
   endgenerate

   ro_race_arbiter #(.TIE_RESULT(TIE_RESULT)) i_arb (
      .clk    (clk_sys),
      .rst_n  (rst_n),
      .start  (start),
      .tc_a_s (tc_sys[0]),
      .tc_b_s (tc_sys[1]),
      .halt   (halt),
      .clr_tgl(clr_tgl),
      .resp   (resp),
      .done   (done)
   );

endmodule

// File: rtl/ro_race_eval_chk.sv
module ro_race_eval_chk #(
   parameter logic TIE_RESULT = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic done,
   input logic resp,
   input logic tc_a_s,
   input logic tc_b_s
);

   p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done);

   p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   p_resp_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> $stable(resp));

   p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(tc_a_s || tc_b_s, 2));

   p_tie_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && $past(tc_a_s && tc_b_s, 2)) |-> (resp == TIE_RESULT));

   p_single_winner_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && $past(tc_a_s ^ tc_b_s, 2)) |-> (resp == $past(tc_a_s, 2)));

endmodule

bind ro_race_eval ro_race_eval_chk #(.TIE_RESULT(TIE_RESULT)) i_chk (
   .clk   (clk_sys),
   .rst_n (rst_n),
   .start (start),
   .done  (done),
   .resp  (resp),
   .tc_a_s(tc_sys[0]),
   .tc_b_s(tc_sys[1])
);

// File: tb/test_ro_race_eval.sv
`timescale 1ns/1ps
module test_ro_race_eval;

   localparam int LOW_BOUND = 1550;
   localparam int HIGH_BOUND = 2400;

   logic clk_sys = 1'b0;
   logic rst_n   = 1'b0;
   logic start   = 1'b0;
   logic osc_a_raw = 1'b0;
   logic osc_b_raw = 1'b0;
   logic tie_mode  = 1'b0;
   logic osc_a, osc_b;
   logic resp, done;
   real  per_a = 4.0;
   real  per_b = 4.4;
   int   checks = 0;
   int   errors = 0;

   always #10 clk_sys = ~clk_sys;
   always #(per_a / 2.0) osc_a_raw = ~osc_a_raw;
   always #(per_b / 2.0) osc_b_raw = ~osc_b_raw;

   assign osc_a = osc_a_raw;
   assign osc_b = tie_mode ? osc_a_raw : osc_b_raw;

   ro_race_eval i_ro_race_eval (
      .clk_sys(clk_sys), .rst_n(rst_n), .osc_a(osc_a), .osc_b(osc_b),
      .start(start), .resp(resp), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(posedge clk_sys); #1 start = 1'b1;
      @(posedge clk_sys); #1 start = 1'b0;
      @(negedge clk_sys);
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk_sys);
   endtask

   // Runs a race from a start pulse and returns cycles until done (or -1).
   task automatic run_race(input string req, output int cyc);
      pulse_start();
      chk(done == 1'b0, "R7 done cleared after start", done, 0);
      cyc = -1;
      for (int i = 1; i <= HIGH_BOUND; i++) begin
         if (done) begin cyc = i; break; end
         @(negedge clk_sys);
      end
      chk(cyc >= LOW_BOUND, {req, " R2 no early result"}, cyc, LOW_BOUND);
   endtask

   task automatic t_reset();
      chk(resp == 1'b0, "R1 resp after reset", resp, 0);
      chk(done == 1'b0, "R1 done after reset", done, 0);
      wait_cycles(600);
      chk(done == 1'b0, "R1 no race without start", done, 0);
   endtask

   task automatic t_a_wins();
      int c;
      per_a = 4.0; per_b = 4.4; tie_mode = 1'b0;
      run_race("A", c);
      chk(c > 0, "R5 done raised", c, 1);
      chk(resp == 1'b1, "R3 A first gives 1", resp, 1);
   endtask

   task automatic t_freeze();
      per_a = 4.8; per_b = 3.6;
      wait_cycles(400);
      chk(done == 1'b1, "R5 done held until start", done, 1);
      chk(resp == 1'b1, "R6 resp latched despite oscillator change", resp, 1);
   endtask

   task automatic t_b_wins_after_stale();
      int c;
      per_a = 4.4; per_b = 4.0;
      run_race("B", c);
      chk(c > 0, "R9 new result after stale flags", c, 1);
      chk(resp == 1'b0, "R3 R9 B first gives 0", resp, 0);
   endtask

   task automatic t_tie();
      int c;
      per_a = 4.0; tie_mode = 1'b1;
      run_race("tie", c);
      chk(c > 0, "R4 done on tie", c, 1);
      chk(resp == 1'b0, "R4 tie gives 0", resp, 0);
      tie_mode = 1'b0;
   endtask

   task automatic t_restart_midrace();
      int c;
      per_a = 4.0; per_b = 4.4;
      pulse_start();
      wait_cycles(700);
      chk(done == 1'b0, "R7 no result mid race", done, 0);
      run_race("restart", c);
      chk(c > 0, "R7 restarted race completes", c, 1);
      chk(resp == 1'b1, "R7 R8 restarted race winner", resp, 1);
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk_sys);
      #1 rst_n = 1'b1;
      @(negedge clk_sys);
      t_reset();
      t_a_wins();
      t_freeze();
      t_b_wins_after_stale();
      t_tie();
      t_restart_midrace();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule